// File: doc/BRIEF.md
# Single-Wire Bus Master Timing Engine

This block produces the bit-level waveforms a bus master needs on a single open-drain data line with a pullup. A host hands it one command at a time: a reset with presence detection, a single bit write, a single bit read, a byte write or a byte read. The engine drives an active-low pull-down enable, samples the line through a two-flop synchronizer, and returns the presence status and the bits it read. Every pulse width and sample point is a microsecond parameter converted to clock cycles from `CLK_FREQ_HZ`.

Bytes go out and come in least significant bit first. A command may also ask for the strong-pullup enable once it has finished. The host uses that to feed a parasite-powered device during a long internal operation. Addressing, command selection and CRC checking stay with the host.

Top module: `swm_engine`

## Requirements
- R1: A reset command (op code 0) drives `pull_n` low for exactly RST_LOW_US worth of cycles, then releases it for RST_LISTEN_US worth of cycles; `busy` is high for the sum of the two.
- R2: After a reset, `presence` is 1 when the synchronized line is low PRES_SMP_US after the release and 0 when it is high; it keeps that value until the next reset.
- R3: A write-bit (op 1, bit `cmd_data[0]`) or write-byte (op 3) slot lasts SLOT_US; it drives `pull_n` low for W1_LOW_US when the bit is 1 and for W0_LOW_US when the bit is 0.
- R4: A read-bit (op 2) slot drives `pull_n` low for RD_LOW_US and samples the synchronized line RD_SMP_US after the slot starts; the bit returns in `rd_data[0]` and the upper bits read 0.
- R5: Byte commands run BYTE_W slots back to back, least significant bit first; a read byte (op 4) returns the first bit read in `rd_data[0]`.
- R6: A command is taken only when `cmd_valid` is high while `busy` is low; `cmd_valid` during `busy` has no effect; `done` pulses for one cycle with `busy` low when a command ends.
- R7: Consecutive slots are separated by released line for at least 1 µs, and falls of `pull_n` in a byte are SLOT_US apart.
- R8: A command issued with `cmd_spu` = 1 raises `spu_en` when it ends; `spu_en` stays high until the next command is taken and is never high while `pull_n` is low.
- R9: Op codes 5 to 7 are ignored: `busy`, `done` and `pull_n` do not move and `spu_en` keeps its value.
- R10: After reset `pull_n` = 1 and `busy`, `done`, `presence`, `spu_en` and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Op code: 0 reset, 1 write bit, 2 read bit, 3 write byte, 4 read byte |
| cmd_data | input | BYTE_W | Data to write (bit 0 for single-bit writes) |
| cmd_spu | input | 1 | Raise strong pullup when this command ends |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| presence | output | 1 | Presence seen in the last reset |
| rd_data | output | BYTE_W | Result of the last read command |
| pull_n | output | 1 | Active-low pull-down enable for the line |
| line_i | input | 1 | Raw line level |
| spu_en | output | 1 | Strong pullup enable |

## Verification
A command taken on clock edge k keeps `busy` high for exactly RST_LOW+RST_LISTEN cycles for a reset, or for the number of slots times SLOT cycles for a bit or byte command. `done`, `presence` and `rd_data` then appear together in the first idle cycle. The bench starts counting at the falling clock edge just after the accepting edge. From there it measures every low run of `pull_n` and the distance between its falls. It compares the result fields at the falling edge where `done` is first seen, so every value is taken half a cycle after the register that produces it. A modeled slave responds from the line itself, so the two-cycle synchronizer delay is covered by sample points that lie well inside the slave's low window.

// File: rtl/swm_pkg.sv
package swm_pkg;

  typedef enum logic [2:0] {
    OP_RESET = 3'd0,
    OP_WBIT  = 3'd1,
    OP_RBIT  = 3'd2,
    OP_WBYTE = 3'd3,
    OP_RBYTE = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RLOW,
    ST_RLSN,
    ST_SLOT
  } st_e;

  function automatic int unsigned us_to_cyc(input int unsigned hz, input int unsigned us);
    return (hz / 1000000) * us;
  endfunction

  function automatic logic op_legal(input logic [2:0] code);
    return code <= 3'd4;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/swm_sync.sv
module swm_sync #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1_q, s2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/swm_phase_timer.sv
module swm_phase_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/swm_shift.sv
module swm_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          shift,
  input  logic          shift_in,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= load_val;
    else if (shift) q <= {shift_in, q[DW-1:1]};
  end
endmodule

// File: rtl/swm_engine.sv
module swm_engine
  import swm_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ   = 50_000_000,
  parameter int unsigned BYTE_W        = 8,
  parameter int unsigned RST_LOW_US    = 500,
  parameter int unsigned RST_LISTEN_US = 480,
  parameter int unsigned PRES_SMP_US   = 70,
  parameter int unsigned W1_LOW_US     = 6,
  parameter int unsigned W0_LOW_US     = 64,
  parameter int unsigned RD_LOW_US     = 6,
  parameter int unsigned RD_SMP_US     = 14,
  parameter int unsigned SLOT_US       = 70
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [BYTE_W-1:0] cmd_data,
  input  logic              cmd_spu,
  output logic              busy,
  output logic              done,
  output logic              presence,
  output logic [BYTE_W-1:0] rd_data,
  output logic              pull_n,
  input  logic              line_i,
  output logic              spu_en
);
  localparam int unsigned C_RST = us_to_cyc(CLK_FREQ_HZ, RST_LOW_US);
  localparam int unsigned C_LSN = us_to_cyc(CLK_FREQ_HZ, RST_LISTEN_US);
  localparam int unsigned C_PS  = us_to_cyc(CLK_FREQ_HZ, PRES_SMP_US);
  localparam int unsigned C_W1  = us_to_cyc(CLK_FREQ_HZ, W1_LOW_US);
  localparam int unsigned C_W0  = us_to_cyc(CLK_FREQ_HZ, W0_LOW_US);
  localparam int unsigned C_RD  = us_to_cyc(CLK_FREQ_HZ, RD_LOW_US);
  localparam int unsigned C_RDS = us_to_cyc(CLK_FREQ_HZ, RD_SMP_US);
  localparam int unsigned C_SLT = us_to_cyc(CLK_FREQ_HZ, SLOT_US);
  localparam int unsigned C_MAX = max3(C_RST, C_LSN, C_SLT);
  localparam int CW  = $clog2(C_MAX + 1);
  localparam int BCW = $clog2(BYTE_W + 1);

  localparam logic [CW-1:0] L_RST = CW'(C_RST);
  localparam logic [CW-1:0] L_LSN = CW'(C_LSN);
  localparam logic [CW-1:0] L_PS  = CW'(C_PS);
  localparam logic [CW-1:0] L_W1  = CW'(C_W1);
  localparam logic [CW-1:0] L_W0  = CW'(C_W0);
  localparam logic [CW-1:0] L_RD  = CW'(C_RD);
  localparam logic [CW-1:0] L_RDS = CW'(C_RDS);
  localparam logic [CW-1:0] L_SLT = CW'(C_SLT);
  localparam logic [BCW-1:0] L_LASTB = BCW'(BYTE_W - 1);

  st_e               st_q;
  logic [2:0]        op_q;
  logic              spu_req_q, spu_q, smp_q, pres_q, done_q;
  logic [BCW-1:0]    bit_q;
  logic [BYTE_W-1:0] rd_q, sh_q, rd_next;
  logic [CW-1:0]     cnt, phase_lim, low_len;
  logic              line_s;

  // named internal events, also observed by the bound checker
  logic accept, phase_end, slot_end, finish, last_slot, is_read, is_byte;

  swm_sync #(.RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(line_i), .q(line_s)
  );

  swm_phase_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .clr(accept || phase_end || (st_q == ST_IDLE)), .cnt(cnt)
  );

  swm_shift #(.DW(BYTE_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(cmd_data),
    .shift(slot_end), .shift_in(smp_q), .q(sh_q)
  );

  assign accept  = cmd_valid && (st_q == ST_IDLE) && op_legal(cmd_op);
  assign is_read = (op_q == OP_RBIT) || (op_q == OP_RBYTE);
  assign is_byte = (op_q == OP_WBYTE) || (op_q == OP_RBYTE);

  always_comb begin
    if (is_read)      low_len = L_RD;
    else if (sh_q[0]) low_len = L_W1;
    else              low_len = L_W0;
  end

  always_comb begin
    case (st_q)
      ST_RLOW: phase_lim = L_RST;
      ST_RLSN: phase_lim = L_LSN;
      ST_SLOT: phase_lim = L_SLT;
      default: phase_lim = CW'(1);
    endcase
  end

  assign phase_end = (st_q != ST_IDLE) && (cnt == phase_lim - 1'b1);
  assign last_slot = is_byte ? (bit_q == L_LASTB) : (bit_q == '0);
  assign slot_end  = phase_end && (st_q == ST_SLOT);
  assign finish    = phase_end && ((st_q == ST_RLSN) || ((st_q == ST_SLOT) && last_slot));
  assign rd_next   = is_byte ? {smp_q, sh_q[BYTE_W-1:1]} : {{(BYTE_W-1){1'b0}}, smp_q};

  always_comb begin
    case (st_q)
      ST_RLOW: pull_n = 1'b0;
      ST_SLOT: pull_n = (cnt >= low_len);
      default: pull_n = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      op_q      <= 3'd0;
      spu_req_q <= 1'b0;
      spu_q     <= 1'b0;
      smp_q     <= 1'b0;
      pres_q    <= 1'b0;
      done_q    <= 1'b0;
      bit_q     <= '0;
      rd_q      <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        op_q      <= cmd_op;
        spu_req_q <= cmd_spu;
        spu_q     <= 1'b0;
        bit_q     <= '0;
        st_q      <= (cmd_op == OP_RESET) ? ST_RLOW : ST_SLOT;
      end
      case (st_q)
        ST_RLOW: if (phase_end) st_q <= ST_RLSN;
        ST_RLSN: if (cnt == L_PS) pres_q <= !line_s;
        ST_SLOT: begin
          if (cnt == L_RDS) smp_q <= line_s;
          if (slot_end && !last_slot) bit_q <= bit_q + 1'b1;
          if (finish && is_read) rd_q <= rd_next;
        end
        default: ;
      endcase
      if (finish) begin
        st_q   <= ST_IDLE;
        done_q <= 1'b1;
        spu_q  <= spu_req_q;
      end
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign done     = done_q;
  assign presence = pres_q;
  assign rd_data  = rd_q;
  assign spu_en   = spu_q;

endmodule

// File: rtl/swm_engine_chk.sv
module swm_engine_chk #(
  parameter int unsigned MAX_LOW = 25000,
  parameter int unsigned MIN_GAP = 50
) (
  input logic clk,
  input logic rst_n,
  input logic pull_n,
  input logic busy,
  input logic done,
  input logic spu_en,
  input logic accept,
  input logic [2:0] cmd_op
);
  localparam int unsigned SAT = 32'h00FF_FFFF;
  int unsigned lo_run, hi_run;
  logic seen_low;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_run   <= 0;
      hi_run   <= 0;
      seen_low <= 1'b0;
    end else begin
      lo_run <= pull_n ? 0 : ((lo_run < SAT) ? lo_run + 1 : lo_run);
      hi_run <= !pull_n ? 0 : ((hi_run < SAT) ? hi_run + 1 : hi_run);
      if (!pull_n) seen_low <= 1'b1;
    end
  end

  p_low_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pull_n |-> (lo_run < MAX_LOW));
  p_accept_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pull_n) && seen_low) |-> (hi_run >= MIN_GAP));
  p_spu_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    spu_en |-> pull_n);
  p_idle_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> pull_n);
  p_bad_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_op > 3'd4) |=> !busy);
endmodule

bind swm_engine swm_engine_chk #(
  .MAX_LOW(C_RST),
  .MIN_GAP(CLK_FREQ_HZ / 1000000)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pull_n(pull_n), .busy(busy), .done(done),
  .spu_en(spu_en), .accept(accept), .cmd_op(cmd_op)
);

// File: tb/tb_swm_engine.sv
`timescale 1ns/1ps
module tb_swm_engine;
  localparam int FREQ = 4_000_000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_data = 8'd0;
  logic cmd_spu = 1'b0;
  logic busy, done, presence, pull_n, spu_en;
  logic [7:0] rd_data;
  logic slave_low = 1'b0;
  logic line;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  assign line = pull_n & ~slave_low;

  swm_engine #(.CLK_FREQ_HZ(FREQ)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_spu(cmd_spu), .busy(busy), .done(done),
    .presence(presence), .rd_data(rd_data), .pull_n(pull_n), .line_i(line),
    .spu_en(spu_en)
  );

  function automatic int c_us(input int us);
    return (FREQ / 1000000) * us;
  endfunction

  // slave model: 0 silent, 1 presence after reset, 2 answers read slots
  int slave_mode = 0;
  logic [7:0] slave_byte = 8'd0;
  int slave_idx = 0;
  int p_wait = 0, p_hold = 0;
  logic pres_armed = 1'b0;
  logic line_prev = 1'b1;

  always @(posedge clk) begin
    line_prev <= line;
    if (p_wait > 0) begin
      p_wait <= p_wait - 1;
      if (p_wait == 1) begin slave_low <= 1'b1; p_hold <= c_us(120); end
    end else if (p_hold > 0) begin
      p_hold <= p_hold - 1;
      if (p_hold == 1) slave_low <= 1'b0;
    end else if (slave_mode == 1 && pres_armed && !line_prev && line) begin
      pres_armed <= 1'b0;
      p_wait <= c_us(30);
    end else if (slave_mode == 2 && line_prev && !line && !slave_low) begin
      if (!slave_byte[slave_idx[2:0]]) begin slave_low <= 1'b1; p_hold <= c_us(30); end
      slave_idx <= slave_idx + 1;
    end
  end

  task automatic chk(input logic ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [2:0] op, input logic [7:0] data, input logic spu,
                         input logic poke, input logic exp_pres, input logic [7:0] exp_rd);
    int t, busy_n, nf, nbits, exp_busy;
    int wid[8];
    int fall[8];
    logic prev;
    logic [7:0] got;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = data; cmd_spu = spu;
    @(negedge clk);
    cmd_valid = 1'b0;
    t = 0; busy_n = 0; nf = 0; prev = 1'b1;
    for (int i = 0; i < 8; i++) begin wid[i] = 0; fall[i] = 0; end
    chk(spu_en == 1'b0, "R8 spu cleared on accept", int'(spu_en), 0);
    while (!done && t < 20000) begin
      if (busy) busy_n++;
      if (!pull_n) begin
        if (prev) begin if (nf < 8) fall[nf] = t; nf++; end
        if (nf > 0 && nf <= 8) wid[nf-1]++;
      end
      prev = pull_n;
      if (poke && t == 100) begin cmd_valid = 1'b1; cmd_op = 3'd0; end
      if (poke && t == 101) cmd_valid = 1'b0;
      @(negedge clk);
      t++;
    end
    nbits = (op == 3'd3 || op == 3'd4) ? 8 : 1;
    exp_busy = (op == 3'd0) ? c_us(500) + c_us(480) : nbits * c_us(70);
    chk(busy_n == exp_busy, poke ? "R6 busy length with ignored request" : "R1/R3 busy length",
        busy_n, exp_busy);
    chk(spu_en == spu, "R8 spu after done", int'(spu_en), int'(spu));
    if (op == 3'd0) begin
      chk(nf == 1, "R1 single reset pulse", nf, 1);
      chk(wid[0] == c_us(500), "R1 reset low width", wid[0], c_us(500));
      chk(presence == exp_pres, "R2 presence", int'(presence), int'(exp_pres));
    end else begin
      chk(nf == nbits, "R5 slot count", nf, nbits);
      for (int i = 0; i + 1 < nbits; i++)
        chk(fall[i+1] - fall[i] == c_us(70), "R7 slot spacing", fall[i+1] - fall[i], c_us(70));
      if (op == 3'd1 || op == 3'd3) begin
        got = 8'd0;
        for (int i = 0; i < nbits; i++)
          got[i] = (wid[i] == c_us(6));
        for (int i = 0; i < nbits; i++)
          chk(wid[i] == (data[i] ? c_us(6) : c_us(64)), "R3 write low width",
              wid[i], data[i] ? c_us(6) : c_us(64));
        chk(got == ((nbits == 8) ? data : {7'd0, data[0]}), "R5 write bit order lsb first",
            int'(got), int'((nbits == 8) ? data : {7'd0, data[0]}));
      end else begin
        for (int i = 0; i < nbits; i++)
          chk(wid[i] == c_us(6), "R4 read low width", wid[i], c_us(6));
        chk(rd_data == exp_rd, "R4/R5 read data", int'(rd_data), int'(exp_rd));
      end
    end
    @(negedge clk);
    chk(done == 1'b0, "R6 done one cycle", int'(done), 0);
  endtask

  task automatic set_slave(input int mode, input logic [7:0] b);
    slave_mode = mode; slave_byte = b; slave_idx = 0; pres_armed = (mode == 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [2:0] op;
    logic [7:0] d;
    logic sp, pr;
    void'($urandom(32'h5EED_0001));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(pull_n == 1'b1, "R10 pull_n", int'(pull_n), 1);
    chk(busy == 1'b0, "R10 busy", int'(busy), 0);
    chk(done == 1'b0, "R10 done", int'(done), 0);
    chk(presence == 1'b0, "R10 presence", int'(presence), 0);
    chk(spu_en == 1'b0, "R10 spu_en", int'(spu_en), 0);
    chk(rd_data == 8'd0, "R10 rd_data", int'(rd_data), 0);

    set_slave(1, 8'd0); run_cmd(3'd0, 8'd0, 1'b0, 1'b0, 1'b1, 8'd0);
    set_slave(0, 8'd0); run_cmd(3'd0, 8'd0, 1'b0, 1'b0, 1'b0, 8'd0);
    run_cmd(3'd3, 8'hA5, 1'b0, 1'b0, 1'b0, 8'd0);
    run_cmd(3'd1, 8'h01, 1'b0, 1'b0, 1'b0, 8'd0);
    run_cmd(3'd1, 8'hFE, 1'b0, 1'b0, 1'b0, 8'd0);
    set_slave(2, 8'h3C); run_cmd(3'd4, 8'd0, 1'b0, 1'b0, 1'b0, 8'h3C);
    set_slave(2, 8'h00); run_cmd(3'd2, 8'd0, 1'b0, 1'b0, 1'b0, 8'h00);
    set_slave(2, 8'h01); run_cmd(3'd2, 8'd0, 1'b0, 1'b0, 1'b0, 8'h01);
    set_slave(0, 8'd0);
    // R8: strong pullup held after a command that asked for it
    run_cmd(3'd3, 8'h44, 1'b1, 1'b0, 1'b0, 8'h01);
    repeat (20) @(negedge clk);
    chk(spu_en == 1'b1 && pull_n == 1'b1, "R8 spu held while idle", int'(spu_en), 1);
    // R9: illegal op code ignored
    @(negedge clk); cmd_valid = 1'b1; cmd_op = 3'd6; cmd_data = 8'h00;
    @(negedge clk); cmd_valid = 1'b0;
    begin
      int moved = 0;
      for (int i = 0; i < 30; i++) begin
        if (busy || done || !pull_n || !spu_en) moved++;
        @(negedge clk);
      end
      chk(moved == 0, "R9 illegal op ignored", moved, 0);
    end
    // R6: request while busy has no effect
    run_cmd(3'd3, 8'h0F, 1'b0, 1'b1, 1'b0, 8'h01);

    for (int n = 0; n < 12; n++) begin
      op = 3'($urandom_range(0, 4));
      d  = 8'($urandom);
      sp = 1'($urandom);
      pr = 1'($urandom);
      if (op == 3'd0) set_slave(pr ? 1 : 0, 8'd0);
      else if (op == 3'd2 || op == 3'd4) set_slave(2, d);
      else set_slave(0, 8'd0);
      run_cmd(op, d, sp, 1'b0, pr, (op == 3'd4) ? d : {7'd0, d[0]});
      if (op == 3'd0) pr = pr;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule